// File: doc/BRIEF.md
# Serial DAC Input Register

This block is the digital receive side of a single-channel serial digital-to-analog converter. A host drives three wires: an active-low frame select, a serial clock and a serial data line. The block brings the three wires into its own system clock domain through a synchronizer chain. It takes one data bit on each falling serial clock edge while the frame is selected, most significant bit first. When the frame select is released, it moves the converter code into the output register.

A parameter picks one of two variants. In the narrow variant the input word is 16 bits long and carries a 14-bit code. In the wide variant the word is 24 bits long and carries a 16-bit code. In both the code is the low-order part of the word, and the bits above it are ignored. A frame counts only when the number of serial clock falls it holds equals the word length exactly. Any other frame is thrown away and leaves the output as it was. Each accepted frame raises a one-cycle update strobe together with the new code.

Top module: `dacin_top`

## Requirements
- R1: After reset, dacCode is zero and dacUpdate is low.
- R2: With WIDE_MODE=0, a frame of exactly 16 falling serClk edges while frameSelN is low loads word bits [13:0] into dacCode. Word bits [15:14] have no effect.
- R3: With WIDE_MODE=1, a frame of exactly 24 falling serClk edges loads word bits [15:0] into dacCode. Word bits [23:16] have no effect.
- R4: serData is sampled on the falling serClk edge. The first bit of a frame is the most significant bit of the word, and the last bit is bit 0.
- R5: A frame that ends (frameSelN rises) with fewer edges than the word length leaves dacCode unchanged and produces no dacUpdate.
- R6: A frame with more edges than the word length is also discarded: dacCode stays unchanged and dacUpdate stays low.
- R7: dacUpdate is high for exactly one clk cycle per accepted frame. It is high in the same cycle in which dacCode first shows the new code.
- R8: serClk edges while frameSelN is high shift nothing and count nothing. A following complete frame loads the correct code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than serClk |
| rstN | input | 1 | Active-low asynchronous reset |
| frameSelN | input | 1 | Active-low frame select from the host |
| serClk | input | 1 | Serial clock; data taken on its falling edge |
| serData | input | 1 | Serial data, MSB first |
| dacCode | output | CODE_W (14 or 16) | Latched converter code |
| dacUpdate | output | 1 | One-cycle strobe marking a code load |

## Verification
The bench sends frames with set padding bits, for example a narrow word 0xC000 that must give code 0. A design that took the code from the top of the word would fail this. It sends 0x0001-style codes that only a design shifting in the correct direction will match. It sends frames one edge short and one edge long. A design that latched on a loose count check would raise an unexpected strobe or change the code on these. It also toggles the serial clock on one instance while that instance is deselected. A design that counted those edges would reject or corrupt the next real frame.

// File: rtl/dacin_pkg.sv
package dacin_pkg;

  typedef struct packed {
    logic shiftEn;
    logic load;
    logic dinBit;
  } dacStrobes_t;

  function automatic int codeWidth(bit wide);
    return wide ? 16 : 14;
  endfunction

  function automatic int wordWidth(bit wide);
    return wide ? 24 : 16;
  endfunction

endpackage

// File: rtl/dacin_sync.sv
module dacin_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[s] <= RST_VAL;
      end else if (s == 0) begin
        stageQ[s] <= asyncIn;
      end else begin
        stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/dacin_ctrl.sv
module dacin_ctrl
  import dacin_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int CNT_W = $clog2(WORD_W + 2)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        fsCur,
  input  logic        sclkCur,
  input  logic        dinCur,
  output dacStrobes_t strb
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

  logic             fsPrev;
  logic             sclkPrev;
  logic [CNT_W-1:0] bitCount;
  logic             sclkFall;
  logic             fsRise;
  logic             fsFall;
  logic             frameLow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      fsPrev   <= fsCur;
      sclkPrev <= sclkCur;
    end
  end

  assign sclkFall = sclkPrev & ~sclkCur;
  assign fsRise   = fsCur & ~fsPrev;
  assign fsFall   = fsPrev & ~fsCur;
  assign frameLow = ~fsCur;

  // Counter saturates one past the word length so overlong frames stay rejected.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (fsRise || fsFall) begin
      bitCount <= '0;
    end else if (sclkFall && frameLow && bitCount != OVER) begin
      bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    strb.shiftEn = sclkFall & frameLow;
    strb.load    = fsRise & (bitCount == FULL);
    strb.dinBit  = dinCur;
  end

  p_idle_count_r8 : assert property (@(posedge clk) disable iff (!rstN)
    (fsPrev && fsCur) |-> (bitCount == '0));

  p_count_bound_r6 : assert property (@(posedge clk) disable iff (!rstN)
    bitCount <= OVER);

  p_clear_after_end_r5 : assert property (@(posedge clk) disable iff (!rstN)
    fsRise |=> (bitCount == '0));

endmodule

// File: rtl/dacin_dp.sv
module dacin_dp
  import dacin_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobes_t       strb,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacUpdate
);

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.dinBit};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      dacUpdate <= 1'b0;
    end else begin
      dacUpdate <= strb.load;
      if (strb.load) begin
        dacCode <= shiftReg[CODE_W-1:0];
      end
    end
  end

  p_msb_first_r4 : assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |=> (shiftReg[0] == $past(strb.dinBit)) &&
                     (shiftReg[WORD_W-1:1] == $past(shiftReg[WORD_W-2:0])));

  p_load_low_bits_r2 : assert property (@(posedge clk) disable iff (!rstN)
    dacUpdate |-> (dacCode == $past(shiftReg[CODE_W-1:0])));

  p_code_hold_r5 : assert property (@(posedge clk) disable iff (!rstN)
    !dacUpdate |-> $stable(dacCode));

  p_single_pulse_r7 : assert property (@(posedge clk) disable iff (!rstN)
    dacUpdate |=> !dacUpdate);

endmodule

// File: rtl/dacin_top.sv
module dacin_top
  import dacin_pkg::*;
#(
  parameter bit WIDE_MODE   = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int CODE_W = codeWidth(WIDE_MODE),
  localparam int WORD_W = wordWidth(WIDE_MODE)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameSelN,
  input  logic              serClk,
  input  logic              serData,
  output logic [CODE_W-1:0] dacCode,
  output logic              dacUpdate
);

  logic [2:0]  pinSync;
  dacStrobes_t strb;

  dacin_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({frameSelN, serClk, serData}),
    .syncOut(pinSync)
  );

  dacin_ctrl #(
    .WORD_W(WORD_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .fsCur  (pinSync[2]),
    .sclkCur(pinSync[1]),
    .dinCur (pinSync[0]),
    .strb   (strb)
  );

  dacin_dp #(
    .WORD_W(WORD_W),
    .CODE_W(CODE_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .dacCode  (dacCode),
    .dacUpdate(dacUpdate)
  );

endmodule

// File: tb/dacin_top_tb.sv
`timescale 1ns/1ps
module dacin_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fsN0 = 1'b1;
  logic        fsN1 = 1'b1;
  logic        sclk = 1'b0;
  logic        sdat = 1'b0;
  logic [13:0] codeN;
  logic [15:0] codeW;
  logic        updN;
  logic        updW;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [15:0] expN[$];
  logic [15:0] expW[$];
  string       tagN[$];
  string       tagW[$];
  logic [15:0] lastN = '0;
  logic [15:0] lastW = '0;

  always #2.5 clk = ~clk;

  dacin_top #(.WIDE_MODE(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .frameSelN(fsN0), .serClk(sclk),
    .serData(sdat), .dacCode(codeN), .dacUpdate(updN)
  );

  dacin_top #(.WIDE_MODE(1'b1)) u_dutW (
    .clk(clk), .rstN(rstN), .frameSelN(fsN1), .serClk(sclk),
    .serData(sdat), .dacCode(codeW), .dacUpdate(updW)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: shifts nbits of word MSB first; queues the expected code when told to.
  task automatic sendFrame(input bit wide, input logic [31:0] word, input int nbits,
                           input bit accept, input string req);
    if (wide) fsN1 = 1'b0; else fsN0 = 1'b0;
    #60;
    for (int i = nbits - 1; i >= 0; i--) begin
      sdat = word[i];
      sclk = 1'b1;
      #40;
      sclk = 1'b0;
      #40;
    end
    if (accept) begin
      if (wide) begin expW.push_back(word[15:0]); tagW.push_back(req); lastW = word[15:0]; end
      else begin expN.push_back({2'b00, word[13:0]}); tagN.push_back(req); lastN = {2'b00, word[13:0]}; end
    end
    if (wide) fsN1 = 1'b1; else fsN0 = 1'b1;
    #200;
  endtask

  // Monitor: pops expected codes on each strobe, flags stray and stretched strobes.
  logic prevUpdN = 1'b0;
  logic prevUpdW = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (updN) begin
        if (prevUpdN) check("R7 narrow strobe width", 16'd2, 16'd1);
        else if (expN.size() == 0) check("R5/R6 narrow stray update", 16'd1, 16'd0);
        else check(tagN.pop_front(), {2'b00, codeN}, expN.pop_front());
      end
      if (updW) begin
        if (prevUpdW) check("R7 wide strobe width", 16'd2, 16'd1);
        else if (expW.size() == 0) check("R5/R6 wide stray update", 16'd1, 16'd0);
        else check(tagW.pop_front(), codeW, expW.pop_front());
      end
    end
    prevUpdN <= updN;
    prevUpdW <= updW;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #23;
    check("R1 narrow code after reset", {2'b00, codeN}, 16'h0000);
    check("R1 wide code after reset", codeW, 16'h0000);
    check("R1 strobes after reset", {14'd0, updN, updW}, 16'h0000);
    rstN = 1'b1;
    #50;

    sendFrame(1'b0, 32'h3FFF, 16, 1'b1, "R2 narrow all ones");
    sendFrame(1'b0, 32'hC000, 16, 1'b1, "R2 narrow pad bits ignored");
    sendFrame(1'b0, 32'h0001, 16, 1'b1, "R4 narrow lsb last");
    sendFrame(1'b0, 32'h5A5A, 16, 1'b1, "R2 narrow mixed");
    sendFrame(1'b1, 32'hFF1234, 24, 1'b1, "R3 wide pad bits ignored");
    sendFrame(1'b1, 32'h008001, 24, 1'b1, "R4 wide msb first");
    sendFrame(1'b1, 32'h00FFFF, 24, 1'b1, "R3 wide all ones");

    sendFrame(1'b0, 32'h0155, 10, 1'b0, "R5");
    sendFrame(1'b0, 32'h7FFF, 15, 1'b0, "R5");
    check("R5 narrow code kept after short frame", {2'b00, codeN}, lastN);
    sendFrame(1'b1, 32'h7ABCDE, 23, 1'b0, "R5");
    check("R5 wide code kept after short frame", codeW, lastW);
    sendFrame(1'b0, 32'h1ABCD, 17, 1'b0, "R6");
    check("R6 narrow code kept after long frame", {2'b00, codeN}, lastN);
    sendFrame(1'b1, 32'h1ABCDEF, 25, 1'b0, "R6");
    check("R6 wide code kept after long frame", codeW, lastW);

    // Narrow frames toggle serClk while the wide instance is deselected.
    sendFrame(1'b1, 32'hA5C3E1, 24, 1'b1, "R8 wide after idle clocks");
    sendFrame(1'b0, 32'h2468, 16, 1'b1, "R8 narrow after idle clocks");

    #500;
    check("R7 narrow every accepted frame strobed", 16'(expN.size()), 16'd0);
    check("R7 wide every accepted frame strobed", 16'(expW.size()), 16'd0);
    check("R2 narrow final code", {2'b00, codeN}, lastN);
    check("R3 wide final code", codeW, lastW);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule